// File: doc/BRIEF.md
# Processor Interrupt Interface with Nested Preemption

This block sits between an interrupt distributor and one processor core. Each cycle the distributor presents its best pending candidate (a valid flag, an ID and an 8-bit priority, where a lower number is more urgent). The block holds a small configuration:

- a global signalling enable;
- an 8-bit priority threshold;
- a 3-bit grouping point.

It raises the core's interrupt line when the candidate clears the threshold and is allowed to preempt the interrupt now in service.

Software takes an interrupt by pulsing an acknowledge request. In that cycle the block returns the candidate's ID and marks it active by pushing the ID and priority onto a short stack of nested interrupts. The top of that stack sets the running priority. Writing the same ID to the completion channel later retires it and pops the stack. Nested handling then unwinds in order.

The grouping point sets how many high-order priority bits take part in preemption. Candidates that differ only in the low-order bits cannot interrupt one another. Setting the grouping point to 7 turns nesting off altogether. When nothing can be signalled, an acknowledge returns the reserved ID 1023 and leaves all state alone.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset, all of the following hold:
  - irq is low;
  - run_prio reads 0xFF (idle);
  - enable is clear;
  - the threshold is 0x00;
  - the grouping point is 0.
- R2: A write (wr_en high) takes effect at the next clock edge, and wr_sel selects its meaning:
  - wr_sel 0 loads enable from wr_data bit 0;
  - wr_sel 1 loads the threshold from wr_data bits 7:0;
  - wr_sel 2 loads the grouping point from wr_data bits 2:0;
  - wr_sel 3 is a completion carrying the ID in wr_data.
- R3: While enable is clear, irq stays low and ack_id reads 1023 even when a candidate is valid.
- R4: A valid candidate is signalled only when its priority is numerically lower than the threshold. A threshold of 0xFF passes every priority below 0xFF.
- R5: With no interrupt active, any candidate that passes R3 and R4 is signalled. With interrupts active, the candidate is signalled only if its group priority is strictly lower than the running priority's group priority. The group priority is the priority with bits 0 through the grouping point cleared, for a grouping point of 0 to 6.
- R6: With a grouping point of 7, no candidate is signalled while any interrupt is active.
- R7: ack_id shows cand_id whenever irq is high, and 1023 otherwise. An acknowledge request while irq is high does three things:
  - raises ack_take in that cycle;
  - pushes the candidate;
  - makes run_prio equal to the candidate's priority from the next cycle.
- R8: An acknowledge request while irq is low returns 1023 and raises no ack_take. It leaves run_prio and the active stack unchanged.
- R9: A completion whose ID equals the ID on top of the active stack raises eoi_done in that cycle, with eoi_id set to that ID, and pops the stack. run_prio then reverts to the previous entry, or to 0xFF if the stack is empty.
- R10: A completion whose ID differs from the top of the stack, or that arrives with no interrupt active, is ignored.
- R11: Once DEPTH interrupts are active, irq stays low whatever the candidate.
- R12: A completion in the same cycle as an acknowledge request is ignored, and the acknowledge proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | Distributor has a pending candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority (lower is more urgent) |
| wr_en | input | 1 | Configuration or completion write strobe |
| wr_sel | input | 2 | Write target: 0 enable, 1 threshold, 2 grouping point, 3 completion |
| wr_data | input | 10 | Write data |
| ack_req | input | 1 | Acknowledge request |
| irq | output | 1 | Interrupt line to the core |
| ack_id | output | 10 | ID an acknowledge returns in this cycle (1023 when none) |
| ack_take | output | 1 | Candidate acknowledged and made active this cycle |
| eoi_done | output | 1 | Completion accepted this cycle |
| eoi_id | output | 10 | ID retired by the accepted completion |
| run_prio | output | 8 | Current running priority (0xFF when idle) |

## Verification
A corrupted stack count or entry shows up on run_prio one cycle after the acknowledge or completion that caused it. It shows up on irq in the same cycle, as soon as a candidate near the running group is presented. A wrong top-of-stack ID makes a correct completion drop eoi_done, or lets a wrong one through, in that same cycle.

The bench therefore follows every acknowledge and completion with a candidate chosen to land on one side of the group boundary. It also checks run_prio after each step, so a fault is exposed within one or two cycles.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;

    localparam int PRIO_W = 8;
    localparam int ID_W   = 10;
    localparam int BP_W   = 3;

    localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;
    localparam logic [PRIO_W-1:0] IDLE_PRIO   = 8'hFF;
    localparam logic [BP_W-1:0]   BP_NO_NEST  = 3'd7;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_THRESH = 2'd1,
        SEL_GROUP  = 2'd2,
        SEL_EOI    = 2'd3
    } wsel_e;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } act_entry_t;

    // Bits that form the group priority for a grouping point of 0..6
    function automatic logic [PRIO_W-1:0] group_bits(input logic [BP_W-1:0] bp);
        logic [PRIO_W-1:0] m;
        m = '1;
        if (bp != BP_NO_NEST)
            m = m << (int'(bp) + 1);
        return m;
    endfunction

endpackage

// File: rtl/cif_cfg_regs.sv
module cif_cfg_regs
    import cpu_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wsel_e             wr_sel,
    input  logic [ID_W-1:0]   wr_data,
    output logic              en_q,
    output logic [PRIO_W-1:0] thresh_q,
    output logic [BP_W-1:0]   bp_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            thresh_q <= '0;
            bp_q     <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CTRL:   en_q     <= wr_data[0];
                SEL_THRESH: thresh_q <= wr_data[PRIO_W-1:0];
                SEL_GROUP:  bp_q     <= wr_data[BP_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cif_active_stack.sv
module cif_active_stack
    import cpu_irq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  act_entry_t       push_entry,
    input  logic             pop,
    output act_entry_t       top_entry,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);

    act_entry_t       slot_q [DEPTH];
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] top_idx;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign wr_idx  = IDX_W'(count);
    assign top_idx = IDX_W'(count - 1'b1);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (push && !full)
            count <= count + 1'b1;
        else if (pop && !empty)
            count <= count - 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '{id: SPURIOUS_ID, prio: IDLE_PRIO};
            else if (push && !full && wr_idx == IDX_W'(g))
                slot_q[g] <= push_entry;
        end
    end

    always_comb begin
        if (empty)
            top_entry = '{id: SPURIOUS_ID, prio: IDLE_PRIO};
        else
            top_entry = slot_q[top_idx];
    end

endmodule

// File: rtl/cif_decide.sv
module cif_decide
    import cpu_irq_pkg::*;
(
    input  logic              cand_valid,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              en,
    input  logic [PRIO_W-1:0] thresh,
    input  logic [BP_W-1:0]   bp,
    input  logic              stk_empty,
    input  logic              stk_full,
    input  logic [PRIO_W-1:0] run_prio,
    output logic              signal
);

    logic [PRIO_W-1:0] gmask;
    logic              below_thresh;
    logic              may_preempt;

    assign gmask        = group_bits(bp);
    assign below_thresh = cand_prio < thresh;

    always_comb begin
        if (stk_empty)
            may_preempt = 1'b1;
        else if (stk_full || bp == BP_NO_NEST)
            may_preempt = 1'b0;
        else
            may_preempt = (cand_prio & gmask) < (run_prio & gmask);
    end

    assign signal = en && cand_valid && below_thresh && may_preempt;

endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
    import cpu_irq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ID_W-1:0]   wr_data,
    input  logic              ack_req,
    output logic              irq,
    output logic [ID_W-1:0]   ack_id,
    output logic              ack_take,
    output logic              eoi_done,
    output logic [ID_W-1:0]   eoi_id,
    output logic [PRIO_W-1:0] run_prio
);

    wsel_e             sel;
    logic              en_q;
    logic [PRIO_W-1:0] thresh_q;
    logic [BP_W-1:0]   bp_q;
    act_entry_t        top_entry;
    act_entry_t        new_entry;
    logic              stk_empty;
    logic              stk_full;
    logic [CNT_W-1:0]  depth_q;
    logic              sig;

    assign sel = wsel_e'(wr_sel);

    cif_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (sel),
        .wr_data  (wr_data),
        .en_q     (en_q),
        .thresh_q (thresh_q),
        .bp_q     (bp_q)
    );

    cif_decide u_decide (
        .cand_valid (cand_valid),
        .cand_prio  (cand_prio),
        .en         (en_q),
        .thresh     (thresh_q),
        .bp         (bp_q),
        .stk_empty  (stk_empty),
        .stk_full   (stk_full),
        .run_prio   (top_entry.prio),
        .signal     (sig)
    );

    assign new_entry = '{id: cand_id, prio: cand_prio};
    assign ack_take  = ack_req && sig;
    assign eoi_done  = wr_en && sel == SEL_EOI && !ack_req && !stk_empty
                       && wr_data == top_entry.id;

    cif_active_stack #(.DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst        (rst),
        .push       (ack_take),
        .push_entry (new_entry),
        .pop        (eoi_done),
        .top_entry  (top_entry),
        .empty      (stk_empty),
        .full       (stk_full),
        .count      (depth_q)
    );

    assign irq      = sig;
    assign ack_id   = sig ? cand_id : SPURIOUS_ID;
    assign eoi_id   = top_entry.id;
    assign run_prio = top_entry.prio;

endmodule

// File: rtl/cpu_irq_chk.sv
module cpu_irq_chk
    import cpu_irq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
)(
    input logic             clk,
    input logic             rst,
    input logic             irq,
    input logic             ack_req,
    input logic             ack_take,
    input logic [ID_W-1:0]  ack_id,
    input logic             eoi_done,
    input logic             cand_valid,
    input logic             en_q,
    input logic [BP_W-1:0]  bp_q,
    input logic [CNT_W-1:0] depth,
    input logic             stk_empty
);

    // R3
    disabled_silent_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> !irq);

    // R8
    spurious_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_req && !irq) |-> (ack_id == SPURIOUS_ID && !ack_take));

    // R7
    ack_push_chk: assert property (@(posedge clk) disable iff (rst)
        ack_take |=> depth == $past(depth) + 1'b1);

    // R9
    eoi_pop_chk: assert property (@(posedge clk) disable iff (rst)
        eoi_done |=> depth == $past(depth) - 1'b1);

    // R11
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        depth <= CNT_W'(DEPTH));

    // R6
    no_nest_chk: assert property (@(posedge clk) disable iff (rst)
        (bp_q == BP_NO_NEST && !stk_empty) |-> !irq);

    // R5
    irq_needs_cand_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> cand_valid);

endmodule

bind cpu_irq_iface cpu_irq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq        (irq),
    .ack_req    (ack_req),
    .ack_take   (ack_take),
    .ack_id     (ack_id),
    .eoi_done   (eoi_done),
    .cand_valid (cand_valid),
    .en_q       (en_q),
    .bp_q       (bp_q),
    .depth      (depth_q),
    .stk_empty  (stk_empty)
);

// File: tb/test_cpu_irq_iface.sv
module test_cpu_irq_iface;

    logic       clk = 1'b0;
    logic       rst;
    logic       cand_valid;
    logic [9:0] cand_id;
    logic [7:0] cand_prio;
    logic       wr_en;
    logic [1:0] wr_sel;
    logic [9:0] wr_data;
    logic       ack_req;
    logic       irq;
    logic [9:0] ack_id;
    logic       ack_take;
    logic       eoi_done;
    logic [9:0] eoi_id;
    logic [7:0] run_prio;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    cpu_irq_iface #(.DEPTH(4)) i_cpu_irq_iface (
        .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_id(cand_id),
        .cand_prio(cand_prio), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ack_req(ack_req), .irq(irq), .ack_id(ack_id), .ack_take(ack_take),
        .eoi_done(eoi_done), .eoi_id(eoi_id), .run_prio(run_prio)
    );

    typedef struct packed {
        logic       valid;
        logic [7:0] prio;
        logic [9:0] id;
        logic       ack;
        logic       exp_irq;
        logic [9:0] exp_id;
    } vec_t;

    // Threshold 0xF0, grouping point 3 (group bits 7:4), enabled
    localparam vec_t VEC [6] = '{
        '{1'b1, 8'h80, 10'd40, 1'b0, 1'b1, 10'd40},
        '{1'b1, 8'h80, 10'd40, 1'b1, 1'b1, 10'd40},
        '{1'b1, 8'h88, 10'd41, 1'b0, 1'b0, 10'd1023},
        '{1'b1, 8'h70, 10'd42, 1'b1, 1'b1, 10'd42},
        '{1'b1, 8'hF0, 10'd43, 1'b0, 1'b0, 10'd1023},
        '{1'b0, 8'h10, 10'd44, 1'b0, 1'b0, 10'd1023}
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [9:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cand(input logic v, input logic [7:0] p, input logic [9:0] id);
        cand_valid = v; cand_prio = p; cand_id = id;
        #2;
    endtask

    // Acknowledge a signalled candidate; call at a negedge
    task automatic take(input logic [7:0] p, input logic [9:0] id);
        cand(1'b1, p, id);
        ack_req = 1'b1;
        #1;
        check("R7 take", ack_take, 1);
        @(negedge clk);
        ack_req = 1'b0;
    endtask

    // Completion with sampling of eoi_done in the same cycle; call at a negedge
    task automatic finish_irq(input logic [9:0] id, input logic exp_done, input string req);
        wr_en = 1'b1; wr_sel = 2'd3; wr_data = id;
        #2;
        check(req, eoi_done, exp_done);
        if (exp_done) check({req, " id"}, eoi_id, id);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        cand_valid = 0; cand_id = 0; cand_prio = 0;
        wr_en = 0; wr_sel = 0; wr_data = 0; ack_req = 0;
        do_reset();

        // R1 reset state (R3: enable clear blocks signalling)
        @(negedge clk);
        cand(1'b1, 8'h00, 10'd5);
        check("R1 irq", irq, 0);
        check("R1 run_prio", run_prio, 8'hFF);
        check("R3 ack_id", ack_id, 1023);
        wr(2'd1, 10'h0FF);
        cand(1'b1, 8'h10, 10'd5);
        check("R3 disabled irq", irq, 0);
        ack_req = 1'b1; #1;
        check("R8 no take", ack_take, 0);
        @(negedge clk); ack_req = 1'b0; #1;
        check("R8 run unchanged", run_prio, 8'hFF);

        // R2 enable write takes effect next cycle; R4 idle threshold passes 0xFE
        wr(2'd0, 10'd1);
        cand(1'b1, 8'hFE, 10'd6);
        check("R4 idle threshold", irq, 1);
        check("R2 enable", ack_id, 6);

        // Table walk: threshold 0xF0, grouping point 3
        wr(2'd1, 10'h0F0);
        wr(2'd2, 10'd3);
        for (int i = 0; i < 6; i++) begin
            cand(VEC[i].valid, VEC[i].prio, VEC[i].id);
            ack_req = VEC[i].ack;
            #1;
            check("R5 table irq", irq, VEC[i].exp_irq);
            check("R7 table ack_id", ack_id, VEC[i].exp_id);
            @(negedge clk);
            ack_req = 1'b0;
        end
        #1;
        check("R7 run_prio", run_prio, 8'h70);

        // R10 mismatched completion ignored
        finish_irq(10'd40, 1'b0, "R10 mismatch");
        cand(1'b1, 8'h75, 10'd44);
        check("R10 state kept", irq, 0);
        check("R10 run kept", run_prio, 8'h70);
        // R9 matching completion
        finish_irq(10'd42, 1'b1, "R9 pop");
        cand(1'b1, 8'h75, 10'd44);
        check("R9 run revert", run_prio, 8'h80);
        check("R9 preempt again", irq, 1);
        finish_irq(10'd40, 1'b1, "R9 pop last");
        #1;
        check("R9 idle", run_prio, 8'hFF);
        finish_irq(10'd40, 1'b0, "R10 empty");

        // R11 full stack, grouping point 0
        do_reset();
        wr(2'd0, 10'd1);
        wr(2'd1, 10'h0FF);
        take(8'h40, 10'd1);
        take(8'h30, 10'd2);
        take(8'h20, 10'd3);
        take(8'h10, 10'd4);
        cand(1'b1, 8'h00, 10'd9);
        check("R11 full irq", irq, 0);
        check("R11 run", run_prio, 8'h10);
        finish_irq(10'd4, 1'b1, "R9 unwind");
        finish_irq(10'd3, 1'b1, "R9 unwind");
        finish_irq(10'd2, 1'b1, "R9 unwind");
        finish_irq(10'd1, 1'b1, "R9 unwind");
        #1;
        check("R9 unwound", run_prio, 8'hFF);

        // R6 grouping point 7: no nesting
        wr(2'd2, 10'd7);
        take(8'h80, 10'd40);
        cand(1'b1, 8'h10, 10'd50);
        check("R6 no nest", irq, 0);

        // R5 grouping point 6: only bit 7 counts
        wr(2'd2, 10'd6);
        cand(1'b1, 8'h90, 10'd51);
        check("R5 same group", irq, 0);
        cand(1'b1, 8'h10, 10'd50);
        check("R5 higher group", irq, 1);

        // R12 ack and completion together: completion ignored
        ack_req = 1'b1; wr_en = 1'b1; wr_sel = 2'd3; wr_data = 10'd40;
        #1;
        check("R12 eoi ignored", eoi_done, 0);
        check("R12 ack taken", ack_take, 1);
        @(negedge clk);
        ack_req = 1'b0; wr_en = 1'b0;
        #1;
        check("R12 run", run_prio, 8'h10);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule